// File: doc/BRIEF.md
# Sequential Integer ALU with Ordering Status

This block is a 32-bit integer arithmetic and logic unit that executes one operation per request. The caller presents an 8-bit operation code, the current value of the destination register (called the accumulator operand below) and the value of the second operand, then raises `start` for one cycle. When `done` pulses, `result` and `result_wr` tell the caller what, if anything, to write back into the destination register. Addition, subtraction, low-half multiplication, the bitwise operations and the shifts finish in a single cycle. Quotient and remainder go through a restoring divider that retires one bit per cycle.

A dedicated compare operation writes nothing back. It instead loads a three-bit ordering status with exactly one of less, equal or greater, comparing the accumulator operand with the second operand as signed numbers. Division by zero raises `div_zero` and suppresses the write-back. Codes outside the supported set complete without any effect.

The control is a three-state machine. **IDLE** accepts `start`. **DIVIDE** waits for the divider. **FINISH** presents `done` for one cycle. The transitions are:
- IDLE→FINISH on a single-cycle, compare, unsupported or divide-by-zero request.
- IDLE→DIVIDE on a quotient or remainder request with a non-zero divisor.
- DIVIDE→FINISH when the divider reports its last step.
- FINISH→IDLE always.

Top module: `seq_alu`

## Requirements
- R1: After reset, `busy`, `done`, `result_wr` and `div_zero` are 0, `result` is 0 and `status_lge` is 3'b000.
- R2: Code 0x11 yields acc+opnd, 0x12 yields acc−opnd and 0x13 yields the low 32 bits of acc×opnd, all wrapping modulo 2^32, with `result_wr`=1.
- R3: Code 0x16 yields acc AND opnd, 0x17 yields acc OR opnd and 0x18 yields acc XOR opnd, with `result_wr`=1.
- R4: Code 0x19 shifts acc left and code 0x1A shifts it right (logical), both by opnd taken as unsigned and filling with zeros. Any amount of 32 or more yields 0.
- R5: Code 0x14 yields the signed quotient truncated toward zero. Code 0x15 yields the remainder, which carries the sign of the dividend. −2^31 divided by −1 gives quotient 0x80000000 and remainder 0. Both set `result_wr`=1.
- R6: Codes 0x14 and 0x15 with opnd=0 set `div_zero`=1 and `result_wr`=0, leave `result` and `status_lge` unchanged, and complete with single-cycle latency.
- R7: Code 0x1F sets `status_lge` to 3'b100 (acc<opnd), 3'b010 (equal) or 3'b001 (acc>opnd), compared as signed values. It sets `result_wr`=0 and leaves `result` unchanged.
- R8: Any other code completes with `result_wr`=0 and `div_zero`=0, leaving `result` and `status_lge` unchanged.
- R9: With the start edge counted as edge 1, `done` is high after edge 1 for single-cycle work and after edge 34 (WIDTH+2) for a division. It is a one-cycle pulse, and `busy` is high from the start edge up to and including the `done` cycle.
- R10: `start` is ignored while `busy` is high: the running operation's result and latency are unaffected and no second `done` follows.
- R11: `result` and `status_lge` change only in the cycle where `done` rises, and `div_zero` returns to 0 on the next completion that is not a division by zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| opcode | input | 8 | Operation code |
| acc_val | input | 32 | Destination register value (first operand) |
| opnd_val | input | 32 | Second operand value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Value to write back to the destination register |
| result_wr | output | 1 | Write-back is required for the completed operation |
| status_lge | output | 3 | Ordering status {less, equal, greater} |
| div_zero | output | 1 | Last completed operation was a division by zero |

## Verification
Single-cycle work, compare, unsupported codes and division by zero are due one edge after the start edge. Quotient and remainder are due 34 edges after it: one edge to load the divider, 32 steps, and one edge to capture the result. The bench drives on falling edges, counts falling edges from the start edge until it sees `done`, and compares that count with the expected latency before it reads any output. Result, write flag and status are therefore sampled exactly in the `done` cycle. A request issued mid-division checks that the count and the result of the running operation do not move.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam logic [7:0] OPC_ADD = 8'h11;
    localparam logic [7:0] OPC_SUB = 8'h12;
    localparam logic [7:0] OPC_MUL = 8'h13;
    localparam logic [7:0] OPC_DIV = 8'h14;
    localparam logic [7:0] OPC_MOD = 8'h15;
    localparam logic [7:0] OPC_AND = 8'h16;
    localparam logic [7:0] OPC_OR  = 8'h17;
    localparam logic [7:0] OPC_XOR = 8'h18;
    localparam logic [7:0] OPC_SHL = 8'h19;
    localparam logic [7:0] OPC_SHR = 8'h1A;
    localparam logic [7:0] OPC_CMP = 8'h1F;

    localparam int ST_LESS  = 2;
    localparam int ST_EQUAL = 1;
    localparam int ST_GREAT = 0;

    typedef enum logic [2:0] {
        K_WRITE,
        K_QUOT,
        K_REM,
        K_ORDER,
        K_NONE
    } op_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DIVIDE,
        S_FINISH
    } alu_state_e;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  logic [7:0] opcode,
    output op_kind_e   kind
);
    always_comb begin
        unique case (opcode)
            OPC_ADD, OPC_SUB, OPC_MUL,
            OPC_AND, OPC_OR,  OPC_XOR,
            OPC_SHL, OPC_SHR:           kind = K_WRITE;
            OPC_DIV:                    kind = K_QUOT;
            OPC_MOD:                    kind = K_REM;
            OPC_CMP:                    kind = K_ORDER;
            default:                    kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [7:0]       opcode,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] y,
    output logic [2:0]       order
);
    localparam int SHW = $clog2(WIDTH);

    logic             shift_big;
    logic [SHW-1:0]   shamt;
    logic [WIDTH-1:0] product;

    assign shift_big = (b >= WIDTH'(WIDTH));
    assign shamt     = b[SHW-1:0];
    assign product   = a * b;

    always_comb begin
        unique case (opcode)
            OPC_ADD: y = a + b;
            OPC_SUB: y = a - b;
            OPC_MUL: y = product;
            OPC_AND: y = a & b;
            OPC_OR:  y = a | b;
            OPC_XOR: y = a ^ b;
            OPC_SHL: y = shift_big ? '0 : (a << shamt);
            OPC_SHR: y = shift_big ? '0 : (a >> shamt);
            default: y = '0;
        endcase
    end

    always_comb begin
        order = 3'b000;
        if ($signed(a) < $signed(b))
            order[ST_LESS] = 1'b1;
        else if (a == b)
            order[ST_EQUAL] = 1'b1;
        else
            order[ST_GREAT] = 1'b1;
    end
endmodule

// File: rtl/alu_divider.sv
module alu_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quot,
    output logic [WIDTH-1:0] rem,
    output logic             fin
);
    localparam int CW = $clog2(WIDTH);

    logic [WIDTH-1:0] q_reg, r_reg, d_reg;
    logic [CW-1:0]    cnt;
    logic             running, neg_q, neg_r;
    logic [WIDTH:0]   shifted, trial;

    assign shifted = {r_reg, q_reg[WIDTH-1]};
    assign trial   = shifted - {1'b0, d_reg};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_reg   <= '0;
            r_reg   <= '0;
            d_reg   <= '0;
            cnt     <= '0;
            running <= 1'b0;
            neg_q   <= 1'b0;
            neg_r   <= 1'b0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                q_reg   <= dividend[WIDTH-1] ? -dividend : dividend;
                d_reg   <= divisor[WIDTH-1]  ? -divisor  : divisor;
                r_reg   <= '0;
                cnt     <= '0;
                running <= 1'b1;
                neg_q   <= dividend[WIDTH-1] ^ divisor[WIDTH-1];
                neg_r   <= dividend[WIDTH-1];
            end else if (running) begin
                if (!trial[WIDTH]) begin
                    r_reg <= trial[WIDTH-1:0];
                    q_reg <= {q_reg[WIDTH-2:0], 1'b1};
                end else begin
                    r_reg <= shifted[WIDTH-1:0];
                    q_reg <= {q_reg[WIDTH-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == CW'(WIDTH-1)) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                end
            end
        end
    end

    assign quot = neg_q ? -q_reg : q_reg;
    assign rem  = neg_r ? -r_reg : r_reg;
endmodule

// File: rtl/seq_alu.sv
module seq_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [WIDTH-1:0] acc_val,
    input  logic [WIDTH-1:0] opnd_val,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             result_wr,
    output logic [2:0]       status_lge,
    output logic             div_zero
);
    alu_state_e       state, state_nx;
    op_kind_e         kind;
    logic [WIDTH-1:0] dp_y, dv_quot, dv_rem;
    logic [2:0]       dp_order;
    logic             dv_fin, dv_load, want_rem, zero_div, accept;

    alu_decode u_dec (
        .opcode (opcode),
        .kind   (kind)
    );

    alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .opcode (opcode),
        .a      (acc_val),
        .b      (opnd_val),
        .y      (dp_y),
        .order  (dp_order)
    );

    alu_divider #(.WIDTH(WIDTH)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dv_load),
        .dividend (acc_val),
        .divisor  (opnd_val),
        .quot     (dv_quot),
        .rem      (dv_rem),
        .fin      (dv_fin)
    );

    assign accept   = (state == S_IDLE) && start;
    assign zero_div = (opnd_val == '0);
    assign dv_load  = accept && (kind == K_QUOT || kind == K_REM) && !zero_div;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = dv_load ? S_DIVIDE : S_FINISH;
            S_DIVIDE: if (dv_fin) state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result     <= '0;
            result_wr  <= 1'b0;
            status_lge <= 3'b000;
            div_zero   <= 1'b0;
            want_rem   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    want_rem <= (kind == K_REM);
                    unique case (kind)
                        K_WRITE: begin
                            result    <= dp_y;
                            result_wr <= 1'b1;
                            div_zero  <= 1'b0;
                        end
                        K_ORDER: begin
                            status_lge <= dp_order;
                            result_wr  <= 1'b0;
                            div_zero   <= 1'b0;
                        end
                        K_QUOT, K_REM: begin
                            if (zero_div) begin
                                result_wr <= 1'b0;
                                div_zero  <= 1'b1;
                            end
                        end
                        default: begin
                            result_wr <= 1'b0;
                            div_zero  <= 1'b0;
                        end
                    endcase
                end
                S_DIVIDE: if (dv_fin) begin
                    result    <= want_rem ? dv_rem : dv_quot;
                    result_wr <= 1'b1;
                    div_zero  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_FINISH);
endmodule

// File: rtl/seq_alu_checker.sv
module seq_alu_checker #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] result,
    input logic             result_wr,
    input logic [2:0]       status_lge,
    input logic             div_zero
);
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_status_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status_lge));

    p_zero_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> !result_wr);

    p_outputs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(status_lge)));
endmodule

bind seq_alu seq_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .result_wr  (result_wr),
    .status_lge (status_lge),
    .div_zero   (div_zero)
);

// File: tb/sim_seq_alu.sv
`timescale 1ns/1ps
module sim_seq_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [31:0] acc_val = '0, opnd_val = '0;
    logic        busy, done, result_wr, div_zero;
    logic [31:0] result;
    logic [2:0]  status_lge;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    seq_alu u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .acc_val(acc_val), .opnd_val(opnd_val), .busy(busy), .done(done),
        .result(result), .result_wr(result_wr), .status_lge(status_lge),
        .div_zero(div_zero)
    );

    localparam logic [31:0] VALS [12] = '{
        32'd0, 32'd1, 32'hFFFF_FFFF, 32'd2, 32'd7, 32'hFFFF_FFF9,
        32'h7FFF_FFFF, 32'h8000_0000, 32'd13, 32'd32, 32'd33, 32'd5 };

    localparam logic [7:0] OPS [11] = '{
        8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h16,
        8'h17, 8'h18, 8'h19, 8'h1A, 8'h1F };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s op=%02h a=%08h b=%08h actual=%08h expected=%08h",
                     req, opcode, acc_val, opnd_val, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] op, input logic [31:0] a,
                          input logic [31:0] b, output int lat);
        @(negedge clk);
        opcode = op; acc_val = a; opnd_val = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [31:0] quot_of(input logic [31:0] a, input logic [31:0] b);
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
        return $signed(a) / $signed(b);
    endfunction

    function automatic logic [31:0] rem_of(input logic [31:0] a, input logic [31:0] b);
        if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h0;
        return $signed(a) % $signed(b);
    endfunction

    function automatic bit listed(input logic [7:0] op);
        foreach (OPS[k]) if (OPS[k] == op) return 1;
        return 0;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog run did not end actual=%0d expected=0", 1);
        summary();
    end

    initial begin
        logic [31:0] exp_res, a, b, probe_res;
        logic [2:0]  exp_st, probe_st;
        logic [7:0]  op;
        bit          exp_wr, exp_err;
        int          lat, exp_lat;

        #9;
        // R1 reset state
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(result == 0 && result_wr == 0, "R1 result", result, 0);
        chk(status_lge == 3'b000 && div_zero == 0, "R1 status", {status_lge, div_zero}, 0);
        rst_n = 1'b1;
        exp_res = '0;
        exp_st = 3'b000;

        // R2 R3 R4 R5 R6 R7 sweep over operand pairs
        foreach (VALS[i]) foreach (VALS[j]) foreach (OPS[k]) begin
            a = VALS[i]; b = VALS[j]; op = OPS[k];
            exp_wr = 1; exp_err = 0; exp_lat = 1;
            case (op)
                8'h11: exp_res = a + b;
                8'h12: exp_res = a - b;
                8'h13: exp_res = a * b;
                8'h16: exp_res = a & b;
                8'h17: exp_res = a | b;
                8'h18: exp_res = a ^ b;
                8'h19: exp_res = (b >= 32) ? 32'h0 : a << b[4:0];
                8'h1A: exp_res = (b >= 32) ? 32'h0 : a >> b[4:0];
                8'h14, 8'h15: begin
                    if (b == 0) begin
                        exp_wr = 0; exp_err = 1;
                    end else begin
                        exp_lat = 34;
                        exp_res = (op == 8'h14) ? quot_of(a, b) : rem_of(a, b);
                    end
                end
                default: begin
                    exp_wr = 0;
                    if ($signed(a) < $signed(b)) exp_st = 3'b100;
                    else if (a == b)             exp_st = 3'b010;
                    else                         exp_st = 3'b001;
                end
            endcase
            run_op(op, a, b, lat);
            chk(lat == exp_lat, "R9 latency", lat, exp_lat);
            if (op == 8'h14 || op == 8'h15) begin
                if (b == 0) chk(div_zero == 1 && result_wr == 0 && result == exp_res,
                                "R6 divide by zero", result, exp_res);
                else        chk(result == exp_res && result_wr == 1,
                                "R5 quotient/remainder", result, exp_res);
            end else if (op == 8'h1F) begin
                chk(status_lge == exp_st && result_wr == 0 && result == exp_res,
                    "R7 compare", {29'd0, status_lge}, {29'd0, exp_st});
            end else if (op == 8'h19 || op == 8'h1A) begin
                chk(result == exp_res && result_wr == 1, "R4 shift", result, exp_res);
            end else if (op >= 8'h16) begin
                chk(result == exp_res && result_wr == 1, "R3 logic", result, exp_res);
            end else begin
                chk(result == exp_res && result_wr == 1, "R2 arith", result, exp_res);
            end
            chk(status_lge == exp_st, "R11 status held", {29'd0, status_lge}, {29'd0, exp_st});
            chk(div_zero == exp_err, "R11 error flag", {31'd0, div_zero}, {31'd0, exp_err});
            @(negedge clk);
            chk(done == 0 && busy == 0, "R9 done pulse", {busy, done}, 0);
        end

        // R8 unsupported codes
        run_op(8'h1F, 32'd3, 32'd9, lat);
        run_op(8'h11, 32'd40, 32'd2, lat);
        probe_res = result;
        probe_st = status_lge;
        for (int c = 0; c < 256; c++) begin
            if (!listed(c[7:0])) begin
                run_op(c[7:0], 32'h1234_5678, 32'd1, lat);
                chk(lat == 1 && result_wr == 0 && div_zero == 0, "R8 no write",
                    {30'd0, result_wr, div_zero}, 0);
                chk(result == probe_res && status_lge == probe_st, "R8 unchanged",
                    result, probe_res);
            end
        end

        // R10 start while dividing is ignored
        @(negedge clk);
        opcode = 8'h14; acc_val = 32'd100; opnd_val = 32'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (3) begin @(negedge clk); lat++; end
        opcode = 8'h11; acc_val = 32'd1; opnd_val = 32'd1; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 60) begin @(negedge clk); lat++; end
        chk(lat == 34 && result == 32'd14, "R10 busy start ignored", result, 32'd14);
        repeat (3) begin
            @(negedge clk);
            chk(done == 0 && busy == 0, "R10 no second done", {busy, done}, 0);
        end

        summary();
    end
endmodule